// File: doc/BRIEF.md
# Flash Data-Polling Status Generator

This block models what a NOR-style flash bank shows on its read bus while an embedded program or erase algorithm runs. A single start pulse stands for the final write strobe of a command sequence. The pulse carries the operation type, the target address, the byte to program, the sectors to erase and an operation length in clock cycles. From the cycle after that pulse, reads return a polling status byte instead of array contents. A dedicated ready/busy output stays low until the algorithm finishes.

Bit 7 of the status byte tells the host where the algorithm is. During a program it is the inverse of bit 7 of the byte being written. During an erase it is 0. When the erase is suspended, a read inside a sector under erase returns 1 in bit 7. An operation aimed only at protected sectors keeps the bank busy for a fixed window and then returns to array reads with the contents untouched. That window is about 1 µs for a program and about 100 µs for an erase, both counted in clock cycles. The first read after the bank goes idle again returns the true bit 7 with bits 6:0 still zero. The whole byte is correct from the next read onward.

The array is a small register store that resets to the erased value 0xFF. The sector number is the top bits of the address.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, ry_by is 1 and rd_data is 0. A read of any address returns 0xFF.
- R2: A read made in the same cycle as cmd_go returns array data. From the next cycle on, ry_by is 0 and reads return status.
- R3: While a program runs, each read returns {~data[7], 7'b0}. ry_by stays 0 for op_len cycles, with op_len = 0 treated as 1.
- R4: When a program completes, the addressed byte holds the programmed value. Bit 7 of a read then equals data[7].
- R5: The first read after the bank returns to idle gives {array[7], 7'b0}. Later reads give the full array byte.
- R6: While an erase runs, reads return 0x00 and ry_by stays 0 for op_len cycles. Afterwards every byte in a selected, unprotected sector reads 0xFF and every other byte is unchanged. erase_sel bit i selects sector i, and the sector of an address is its top two bits.
- R7: susp_req during an erase makes ry_by 1 from the next cycle. Reads inside an erasing sector then return 0x80, and reads elsewhere return array data. resume_req continues the erase, so the busy cycles before and after the suspension add up to op_len.
- R8: A program started during suspend drives ry_by to 0 and gives the R3 status. It then returns to the suspended state (ry_by 1, erasing sectors still read 0x80) with the byte written.
- R9: A program to a sector whose prot_map bit is 1 gives the R3 status for PROG_PROT_NS/CLK_NS cycles (200 by default) and leaves the array unchanged.
- R10: An erase whose selected sectors are all protected reads 0x00 for ERASE_PROT_NS/CLK_NS cycles (20000 by default) and leaves the array unchanged.
- R11: When only some selected sectors are protected, only the unprotected ones are erased.
- R12: cmd_go is ignored while a program or erase is running, and an erase command is ignored during suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Start pulse, equivalent to the final write strobe of a command |
| cmd_erase | input | 1 | 1 = erase, 0 = program |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | DATA_W | Byte to program |
| erase_sel | input | NSECT | Sectors selected for erase |
| prot_map | input | NSECT | Per-sector protection, 1 = protected |
| op_len | input | CNT_W | Operation length in cycles |
| susp_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data or status, updated one cycle after rd_en |
| ry_by | output | 1 | 1 = ready, 0 = embedded algorithm running |

## Verification
The bench mixes random programs with directed cases around the polling window.

It reads in the very cycle of the start pulse. A design that polls one cycle early would return status there instead of old array data. It counts busy cycles for op_len 0 and for both protection timeouts. An off-by-one counter, or one that ignores protection, shows up in those counts.

It suspends an erase part-way, runs a program inside the suspension, issues an erase that must be ignored, and resumes. A design that loses or repeats a count across the suspension breaks the busy total. A design that forgets the erase mask returns wrong data in erasing sectors.

It checks the stale first read after completion and the second read that follows it. It also checks that a protected sector keeps its data through a partial erase.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
// Shared types for the data-polling status generator.
package fps_pkg;
    // Bank operating state seen by the read path and the ready/busy output.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_SPROG = 3'd4
    } fps_state_e;
endpackage

// File: rtl/fps_timer.sv
`timescale 1ns/1ps
// Down-counter that times one embedded operation.
// Assumes: load and run are never both high; zero is high whenever the count is 0.
module fps_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load a new length or count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: a loaded length is what the counter holds next cycle
    p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/fps_array.sv
`timescale 1ns/1ps
// Register model of the flash array. Programming writes a byte. Erasing sets
// every byte of the masked sectors to all ones.
// Assumes: write and erase never happen in the same cycle; the sector is the top address bits.
module fps_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NSECT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              er_en,
    input  logic [NSECT-1:0]  er_mask,
    input  logic [NSECT-1:0]  prot_q,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SECT_W = $clog2(NSECT);

    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_W];
    endfunction

    // Reset to erased, then apply program writes and sector erases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else begin
            if (er_en) begin
                for (int i = 0; i < DEPTH; i++)
                    if (er_mask[sect_of(ADDR_W'(i))])
                        mem[i] <= '1;
            end
            if (wr_en)
                mem[wr_addr] <= wr_data;
        end
    end

    assign rd_q = mem[rd_addr];

    // R9: a completed program never lands in a sector that was protected at its start
    p_no_prot_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !prot_q[sect_of(wr_addr)]);
endmodule

// File: rtl/fps_ctrl.sv
`timescale 1ns/1ps
// Operation sequencer. It accepts start pulses, picks the length (from the
// command or from a protection timeout), handles suspend and resume, and
// requests array updates on completion.
// Assumes: prot_map and erase_sel are sampled at the start pulse only.
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NSECT    = 4,
    parameter int CNT_W    = 16,
    parameter int PROG_TO  = 200,
    parameter int ERASE_TO = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic [NSECT-1:0]  prot_map,
    input  logic [CNT_W-1:0]  op_len,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              a_zero,
    input  logic              b_zero,
    output logic              a_load,
    output logic [CNT_W-1:0]  a_val,
    output logic              a_run,
    output logic              b_load,
    output logic [CNT_W-1:0]  b_val,
    output logic              b_run,
    output fps_state_e        st,
    output logic              pg_bit,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              er_en,
    output logic [NSECT-1:0]  er_mask,
    output logic [NSECT-1:0]  prot_q,
    output logic              finish,
    output logic              ry_by
);
    localparam int SECT_W = $clog2(NSECT);

    fps_state_e        st_n;
    logic [ADDR_W-1:0] pg_addr;
    logic [DATA_W-1:0] pg_data;
    logic              pg_prot;
    logic              er_prot;
    logic              acc_prog;
    logic              acc_erase;
    logic [NSECT-1:0]  eff_mask;
    logic [CNT_W-1:0]  len_m1;
    logic [CNT_W-1:0]  prog_len;
    logic [CNT_W-1:0]  erase_len;
    logic              tgt_prot;

    // Derive start decisions and the lengths of the next operation.
    always_comb begin
        tgt_prot  = prot_map[cmd_addr[ADDR_W-1 -: SECT_W]];
        eff_mask  = erase_sel & ~prot_map;
        len_m1    = (op_len == '0) ? '0 : op_len - 1'b1;
        prog_len  = tgt_prot ? CNT_W'(PROG_TO - 1) : len_m1;
        erase_len = (eff_mask == '0) ? CNT_W'(ERASE_TO - 1) : len_m1;
        acc_prog  = cmd_go && !cmd_erase &&
                    (st == ST_IDLE || (st == ST_SUSP && !resume_req));
        acc_erase = cmd_go && cmd_erase && st == ST_IDLE;
    end

    // Next-state logic, timer control and completion requests.
    always_comb begin
        st_n   = st;
        a_load = 1'b0;
        a_val  = '0;
        a_run  = 1'b0;
        b_load = 1'b0;
        b_val  = '0;
        b_run  = 1'b0;
        wr_en  = 1'b0;
        er_en  = 1'b0;
        finish = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (acc_prog) begin
                    st_n   = ST_PROG;
                    a_load = 1'b1;
                    a_val  = prog_len;
                end else if (acc_erase) begin
                    st_n   = ST_ERASE;
                    a_load = 1'b1;
                    a_val  = erase_len;
                end
            end
            ST_PROG: begin
                if (a_zero) begin
                    wr_en  = !pg_prot;
                    st_n   = ST_IDLE;
                    finish = 1'b1;
                end else begin
                    a_run = 1'b1;
                end
            end
            ST_ERASE: begin
                if (a_zero) begin
                    er_en  = !er_prot;
                    st_n   = ST_IDLE;
                    finish = 1'b1;
                end else begin
                    a_run = 1'b1;
                    if (susp_req && !er_prot)
                        st_n = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (resume_req) begin
                    st_n = ST_ERASE;
                end else if (acc_prog) begin
                    st_n   = ST_SPROG;
                    b_load = 1'b1;
                    b_val  = prog_len;
                end
            end
            ST_SPROG: begin
                if (b_zero) begin
                    wr_en = !pg_prot;
                    st_n  = ST_SUSP;
                end else begin
                    b_run = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register and command capture at accepted starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pg_addr <= '0;
            pg_data <= '0;
            pg_prot <= 1'b0;
            prot_q  <= '0;
            er_mask <= '0;
            er_prot <= 1'b0;
        end else begin
            st <= st_n;
            if (acc_prog) begin
                pg_addr <= cmd_addr;
                pg_data <= cmd_data;
                pg_prot <= tgt_prot;
                prot_q  <= prot_map;
            end
            if (acc_erase) begin
                er_mask <= eff_mask;
                er_prot <= (eff_mask == '0);
            end
        end
    end

    assign wr_addr = pg_addr;
    assign wr_data = pg_data;
    assign pg_bit  = pg_data[DATA_W-1];
    assign ry_by   = (st == ST_IDLE) || (st == ST_SUSP);

    // R2: an accepted start in idle makes the bank busy on the next cycle
    p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_go) |=> !ry_by);
    // R7: a suspend during a running erase reports ready on the next cycle
    p_susp_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && susp_req && !a_zero && !er_prot) |=> ry_by);
    // R8: a program inside a suspension goes back to the suspended state
    p_sprog_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SPROG && b_zero) |=> st == ST_SUSP);
    // R12: a running program keeps its captured command
    p_hold_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> ($stable(pg_addr) && $stable(pg_data)));
endmodule

// File: rtl/fps_readmux.sv
`timescale 1ns/1ps
// Registered read path. It selects array data or a polling status byte from
// the bank state and applies the one-read stale window after completion.
// Assumes: rd_data changes only on a cycle with rd_en high.
module fps_readmux
    import fps_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NSECT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  fps_state_e        st,
    input  logic              pg_bit,
    input  logic [NSECT-1:0]  er_mask,
    input  logic              finish,
    input  logic [DATA_W-1:0] arr_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SECT_W = $clog2(NSECT);
    localparam logic [DATA_W-2:0] LOW0 = '0;

    logic stale;
    logic in_erase_sect;

    assign in_erase_sect = er_mask[rd_addr[ADDR_W-1 -: SECT_W]];

    // Build the read response and track the stale first read after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            stale   <= 1'b0;
        end else begin
            if (finish)
                stale <= 1'b1;
            if (rd_en) begin
                unique case (st)
                    ST_PROG, ST_SPROG: rd_data <= {~pg_bit, LOW0};
                    ST_ERASE:          rd_data <= '0;
                    ST_SUSP:           rd_data <= in_erase_sect ? {1'b1, LOW0} : arr_q;
                    default: begin
                        if (stale) begin
                            rd_data <= {arr_q[DATA_W-1], LOW0};
                            stale   <= 1'b0;
                        end else begin
                            rd_data <= arr_q;
                        end
                    end
                endcase
            end
        end
    end

    // R3: a status read during a program returns the inverted data bit
    p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_PROG || st == ST_SPROG)) |=>
            rd_data[DATA_W-1] == !$past(pg_bit));
    // R6: a status read during an erase returns all zeros
    p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_ERASE) |=> rd_data == '0);
    // R5: the stale read clears its low bits and is used only once
    p_stale_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_IDLE && stale) |=> (rd_data[DATA_W-2:0] == '0 && !stale));
endmodule

// File: rtl/flash_poll_status.sv
`timescale 1ns/1ps
// Top of the data-polling status generator. It joins the sequencer, two
// operation timers (main and program-in-suspend), the array model and the
// read path.
// Assumes: NSECT is a power of two of at least 2; the protection timeouts fit in CNT_W.
module flash_poll_status
    import fps_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int NSECT         = 4,
    parameter int CNT_W         = 16,
    parameter int CLK_NS        = 5,
    parameter int PROG_PROT_NS  = 1000,
    parameter int ERASE_PROT_NS = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic [NSECT-1:0]  prot_map,
    input  logic [CNT_W-1:0]  op_len,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ry_by
);
    localparam int PROG_TO  = PROG_PROT_NS / CLK_NS;
    localparam int ERASE_TO = ERASE_PROT_NS / CLK_NS;
    localparam int NTIMER   = 2;

    fps_state_e        st;
    logic              pg_bit;
    logic              wr_en;
    logic              er_en;
    logic              finish;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] arr_q;
    logic [NSECT-1:0]  er_mask;
    logic [NSECT-1:0]  prot_q;
    logic [NTIMER-1:0] t_load;
    logic [NTIMER-1:0] t_run;
    logic [NTIMER-1:0] t_zero;
    logic [CNT_W-1:0]  t_val [NTIMER];

    fps_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT), .CNT_W(CNT_W),
        .PROG_TO(PROG_TO), .ERASE_TO(ERASE_TO)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(cmd_go), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .erase_sel(erase_sel), .prot_map(prot_map),
        .op_len(op_len), .susp_req(susp_req), .resume_req(resume_req),
        .a_zero(t_zero[0]), .b_zero(t_zero[1]),
        .a_load(t_load[0]), .a_val(t_val[0]), .a_run(t_run[0]),
        .b_load(t_load[1]), .b_val(t_val[1]), .b_run(t_run[1]),
        .st(st), .pg_bit(pg_bit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .er_en(er_en), .er_mask(er_mask), .prot_q(prot_q),
        .finish(finish), .ry_by(ry_by)
    );

    // Timer 0 times top-level operations; timer 1 times programs inside a suspension.
    for (genvar g = 0; g < NTIMER; g++) begin : g_tmr
        fps_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .load(t_load[g]), .load_val(t_val[g]),
            .run(t_run[g]), .zero(t_zero[g])
        );
    end

    fps_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .er_en(er_en), .er_mask(er_mask), .prot_q(prot_q),
        .rd_addr(rd_addr), .rd_q(arr_q)
    );

    fps_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .st(st), .pg_bit(pg_bit),
        .er_mask(er_mask), .finish(finish), .arr_q(arr_q), .rd_data(rd_data)
    );

    // R1: out of reset the bank reports ready
    p_reset_ready_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> ry_by);
endmodule

// File: tb/sim_flash_poll_status.sv
`timescale 1ns/1ps
module sim_flash_poll_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_go = 1'b0;
    logic        cmd_erase = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [3:0]  erase_sel = '0;
    logic [3:0]  prot_map = '0;
    logic [15:0] op_len = '0;
    logic        susp_req = 1'b0;
    logic        resume_req = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        ry_by;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] model [256];

    flash_poll_status u0 (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .erase_sel(erase_sel),
        .prot_map(prot_map), .op_len(op_len), .susp_req(susp_req),
        .resume_req(resume_req), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ry_by(ry_by)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] poll_prog(input logic [7:0] d);
        return {~d[7], 7'b0};
    endfunction

    function automatic logic [7:0] first_read(input logic [7:0] v);
        return {v[7], 7'b0};
    endfunction

    function automatic void model_erase(input logic [3:0] mask);
        for (int i = 0; i < 256; i++)
            if (mask[i/64]) model[i] = 8'hFF;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] q);
        rd_en = 1'b1;
        rd_addr = a;
        tick();
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic start_prog(input logic [7:0] a, input logic [7:0] d, input int len);
        cmd_go = 1'b1; cmd_erase = 1'b0; cmd_addr = a; cmd_data = d; op_len = 16'(len);
        tick();
        cmd_go = 1'b0;
    endtask

    task automatic start_erase(input logic [3:0] sel, input int len);
        cmd_go = 1'b1; cmd_erase = 1'b1; erase_sel = sel; op_len = 16'(len);
        tick();
        cmd_go = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ry_by && n < 30000) begin
            n++;
            tick();
        end
    endtask

    initial begin
        logic [7:0] q;
        logic [7:0] a;
        logic [7:0] d;
        int n, len, pre, post;
        void'($urandom(32'd5150));
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 ready after reset", ry_by, 1);
        check("R1 read bus after reset", rd_data, 0);
        do_read(8'h33, q);
        check("R1 erased array", q, 8'hFF);

        // Preload sector 3 while it is unprotected, then protect it.
        start_prog(8'hC5, 8'h5A, 3);
        wait_ready(n);
        model[8'hC5] = 8'h5A;
        do_read(8'hC5, q);
        check("R5 first read bit7 only", q, first_read(8'h5A));
        prot_map = 4'b1000;

        // R2: a read in the start cycle sees the array, status follows
        cmd_go = 1'b1; cmd_erase = 1'b0; cmd_addr = 8'h07; cmd_data = 8'h11; op_len = 16'd6;
        rd_en = 1'b1; rd_addr = 8'h07;
        tick();
        cmd_go = 1'b0; rd_en = 1'b0;
        check("R2 read in start cycle", rd_data, model[8'h07]);
        check("R2 busy next cycle", ry_by, 0);
        do_read(8'h07, q);
        check("R2 status after start", q, poll_prog(8'h11));
        wait_ready(n);
        model[8'h07] = 8'h11;
        do_read(8'h07, q);
        check("R5 stale read", q, first_read(8'h11));
        do_read(8'h07, q);
        check("R4 full byte", q, 8'h11);

        // R3: zero length counts as one cycle
        start_prog(8'h08, 8'hF0, 0);
        wait_ready(n);
        check("R3 op_len 0 busy", n, 1);
        model[8'h08] = 8'hF0;
        do_read(8'h08, q);
        do_read(8'h08, q);
        check("R4 after len 0", q, 8'hF0);

        // Random programs in unprotected sectors.
        for (int it = 0; it < 40; it++) begin
            a = {2'($urandom % 3), 6'($urandom)};
            d = 8'($urandom);
            len = 3 + int'($urandom % 10);
            start_prog(a, d, len);
            do_read(8'($urandom), q);
            check("R3 program status", q, poll_prog(d));
            wait_ready(n);
            check("R3 program busy length", n + 1, len);
            model[a] = d;
            do_read(a, q);
            check("R5 stale first read", q, first_read(d));
            do_read(a, q);
            check("R4 programmed byte", q, d);
            a = {2'($urandom % 3), 6'($urandom)};
            do_read(a, q);
            check("R4 other byte", q, model[a]);
        end

        // R6: plain erase of sector 0
        start_erase(4'b0001, 25);
        do_read(8'h05, q);
        check("R6 erase status", q, 0);
        wait_ready(n);
        check("R6 erase busy length", n + 1, 25);
        model_erase(4'b0001);
        do_read(8'h05, q);
        check("R6 stale after erase", q, 8'h80);
        do_read(8'h05, q);
        check("R6 erased byte", q, 8'hFF);
        a = 8'h40 | 8'($urandom % 64);
        do_read(a, q);
        check("R6 unselected unchanged", q, model[a]);

        // R7/R8/R12: suspend, program inside, ignored erase, resume.
        model[8'h45] = 8'h00;
        start_prog(8'h45, 8'h00, 3);
        wait_ready(n);
        do_read(8'h45, q);
        do_read(8'h45, q);
        check("R4 preload sector 1", q, 8'h00);
        start_erase(4'b0010, 60);
        pre = 0;
        repeat (5) begin
            if (!ry_by) pre++;
            tick();
        end
        if (!ry_by) pre++;
        susp_req = 1'b1;
        tick();
        susp_req = 1'b0;
        check("R7 ready in suspend", ry_by, 1);
        do_read(8'h45, q);
        check("R7 erasing sector status", q, 8'h80);
        do_read(8'h10, q);
        check("R7 other sector array", q, model[8'h10]);
        start_erase(4'b0100, 5);
        check("R12 erase ignored in suspend", ry_by, 1);
        start_prog(8'h90, 8'h6B, 7);
        check("R8 busy in suspend program", ry_by, 0);
        do_read(8'h90, q);
        check("R8 status in suspend program", q, poll_prog(8'h6B));
        wait_ready(n);
        check("R8 suspend program length", n + 1, 7);
        model[8'h90] = 8'h6B;
        do_read(8'h90, q);
        check("R8 byte written in suspend", q, 8'h6B);
        do_read(8'h45, q);
        check("R8 still suspended", q, 8'h80);
        resume_req = 1'b1;
        tick();
        resume_req = 1'b0;
        wait_ready(post);
        check("R7 busy total across suspend", pre + post, 60);
        model_erase(4'b0010);
        do_read(8'h45, q);
        check("R5 stale after resumed erase", q, 8'h80);
        do_read(8'h45, q);
        check("R6 resumed erase result", q, 8'hFF);
        do_read(8'h90, q);
        check("R12 ignored erase kept sector 2", q, 8'h6B);

        // R12: start pulse during a running program
        start_prog(8'h20, 8'h3C, 20);
        tick();
        tick();
        start_prog(8'h21, 8'h00, 3);
        wait_ready(n);
        check("R12 busy unchanged by second go", n + 3, 20);
        model[8'h20] = 8'h3C;
        do_read(8'h20, q);
        do_read(8'h20, q);
        check("R12 first program stored", q, 8'h3C);
        do_read(8'h21, q);
        check("R12 second program dropped", q, model[8'h21]);

        // R9: program to a protected sector
        start_prog(8'hC5, 8'h00, 5);
        do_read(8'hC5, q);
        check("R9 protected program status", q, 8'h80);
        wait_ready(n);
        check("R9 protected program timeout", n + 1, 200);
        do_read(8'hC5, q);
        check("R9 stale read", q, first_read(8'h5A));
        do_read(8'hC5, q);
        check("R9 protected byte unchanged", q, 8'h5A);

        // R10: erase of protected sectors only
        start_erase(4'b1000, 5);
        do_read(8'hC0, q);
        check("R10 protected erase status", q, 0);
        wait_ready(n);
        check("R10 protected erase timeout", n + 1, 20000);
        do_read(8'hC5, q);
        do_read(8'hC5, q);
        check("R10 protected sector unchanged", q, 8'h5A);

        // R11: partial protection
        start_erase(4'b1100, 10);
        wait_ready(n);
        check("R11 partial erase length", n, 10);
        model_erase(4'b0100);
        do_read(8'h90, q);
        do_read(8'h90, q);
        check("R11 unprotected sector erased", q, 8'hFF);
        do_read(8'hC5, q);
        check("R11 protected sector kept", q, 8'h5A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule